// File: doc/BRIEF.md
# Bus-Controlled Channel Enable Controller

This block is a serial two-wire bus target that owns the enable mask of a four-way downstream bus switch. It watches the open-drain clock and data lines with a fast system clock. It cleans them with a synchronizer and a spike filter, then recognises start and stop conditions. It answers one seven-bit address and either accepts a new mask or reports the mask currently in force. The only things it drives are a pull-down request for the data line and the channel-enable vector that gates the external pass switches.

A mask that a controller writes is not applied at once. It waits in a staging register and goes to the outputs only when the bus sees a stop condition, so that a switch never closes in the middle of a transfer. Two reset sources clear everything: a power-on reset and an active-low reset pin. Both act asynchronously and are released on a clock edge. When they clear the block, every channel is disconnected.

Top module: `chsel_top`

## Requirements
- R1: The block answers the 7-bit address whose upper four bits are binary 1110 and whose lower three bits equal `strap[2:0]`. The address is followed by a direction bit, where 1 means read and 0 means write. A matching address is acknowledged by holding the data line low during the ninth clock.
- R2: An address that does not match gets no acknowledge. Every following byte is ignored until the next start or stop, so the channel mask does not change.
- R3: In a write, each byte after the address is acknowledged. Its bits 3..0 become the new mask, with bit n enabling channel n, and bits 7..4 are ignored. Any combination of channels may be enabled, from none to all four.
- R4: A written mask reaches `chan_en` only after the next stop condition. Until then the previous mask stays on the outputs.
- R5: When several bytes are written in one transaction, only the last one is applied at the stop.
- R6: A read returns one byte, most significant bit first. Bits 7..4 are zero and bits 3..0 are the mask currently on `chan_en`. After the master's not-acknowledge the block releases the line.
- R7: Pulling `rst_in_n` or `por_n` low clears the mask and any staged mask, releases the data line and returns the bus logic to idle. A normal transaction works again once the reset is released.
- R8: A pulse on either line that lasts fewer than `FILT_CYC` system-clock cycles is rejected before start and stop detection. A short data spike while the clock is high therefore neither applies nor loses a staged mask.
- R9: A repeated start inside a transaction restarts address reception. A mask written before the repeated start is still applied only at the final stop, and a read after it returns the old mask.
- R10: `sda_pull` only becomes active while the filtered clock line is low. It is released after a stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| por_n | input | 1 | Power-on reset, active low |
| rst_in_n | input | 1 | External reset pin, active low |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| strap | input | 3 | Low address bits taken from strap pins |
| sda_pull | output | 1 | High to pull the data line low |
| chan_en | output | 4 | Channel enables, bit n closes channel n |

## Verification
Two events can land in the same cycle: the stop condition that commits the staged mask, and the mask's own presence on the read path. The bench provokes this by writing a mask, issuing a repeated start and reading back before the stop. The read must return the old mask, and `chan_en` may change only after the final stop. A second case places a sub-filter data spike at the exact point where a stop would commit a pending mask. The reference model requires the outputs to hold on every clock until a real stop arrives.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AEND,
    ST_AACK,
    ST_WDAT,
    ST_WEND,
    ST_WACK,
    ST_RDAT,
    ST_RACK,
    ST_SKIP
  } bus_state_t;

  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/chsel_rst_sync.sv
module chsel_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_o = stage2_q;

endmodule

// File: rtl/chsel_line_filter.sv
// Two-flop synchronizer followed by a persistence filter: the clean output
// follows the input only after FILT_CYC consecutive differing samples.
module chsel_line_filter #(
  parameter int unsigned FILT_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  localparam int unsigned CNT_W = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYC - 1);

  logic             meta_q;
  logic             sync_q;
  logic             out_q, out_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    out_d = out_q;
    cnt_d = cnt_q;
    if (sync_q == out_q) begin
      cnt_d = '0;
    end else if (cnt_q >= CNT_LAST) begin
      out_d = sync_q;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      out_q  <= 1'b1;
      cnt_q  <= '0;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      out_q  <= out_d;
      cnt_q  <= cnt_d;
    end
  end

  assign line_o = out_q;

endmodule

// File: rtl/chsel_bus_fsm.sv
module chsel_bus_fsm
  import chsel_pkg::*;
#(
  parameter int unsigned              CH        = 4,
  parameter int unsigned              STRAP_W   = 3,
  parameter logic [ADDR_W-1:0]        BASE_ADDR = 7'h70
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_f,
  input  logic               sda_f,
  input  logic [STRAP_W-1:0] strap,
  input  logic [CH-1:0]      cur_sel,
  output logic               sda_pull,
  output logic               wr_fire,
  output logic [CH-1:0]      wr_mask,
  output logic               stop_evt,
  output logic               start_evt
);

  localparam int unsigned FIX_W = ADDR_W - STRAP_W;
  localparam logic [FIX_W-1:0] FIX_BITS = BASE_ADDR[ADDR_W-1:STRAP_W];

  bus_state_t        state_q, state_d;
  logic [2:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              pull_q, pull_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic              scl_p_q, sda_p_q;

  logic              scl_rise, scl_fall;
  logic [BYTE_W-1:0] tx_byte;
  logic              addr_hit;

  // bus events on the filtered lines
  assign scl_rise  =  scl_f & ~scl_p_q;
  assign scl_fall  = ~scl_f &  scl_p_q;
  assign start_evt =  scl_f & scl_p_q &  sda_p_q & ~sda_f;
  assign stop_evt  =  scl_f & scl_p_q & ~sda_p_q &  sda_f;

  assign addr_hit  = (sh_q[BYTE_W-1:1] == {FIX_BITS, strap});

  always_comb begin
    tx_byte         = '0;
    tx_byte[CH-1:0] = cur_sel;
  end

  always_comb begin
    state_d = state_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    pull_d  = pull_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    wr_fire = 1'b0;
    if (start_evt) begin
      state_d = ST_ADDR;
      bit_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_evt) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_WDAT: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_f};
            bit_d = bit_q + 1'b1;
            if (bit_q == 3'd7) begin
              state_d = (state_q == ST_ADDR) ? ST_AEND : ST_WEND;
            end
          end
        end
        ST_AEND: begin
          if (scl_fall) begin
            if (addr_hit) begin
              pull_d  = 1'b1;
              rw_d    = sh_q[0];
              state_d = ST_AACK;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            bit_d = '0;
            if (rw_q) begin
              sh_d    = tx_byte;
              pull_d  = ~tx_byte[BYTE_W-1];
              state_d = ST_RDAT;
            end else begin
              pull_d  = 1'b0;
              state_d = ST_WDAT;
            end
          end
        end
        ST_WEND: begin
          if (scl_fall) begin
            wr_fire = 1'b1;
            pull_d  = 1'b1;
            state_d = ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            bit_d   = '0;
            state_d = ST_WDAT;
          end
        end
        ST_RDAT: begin
          if (scl_fall) begin
            if (bit_q == 3'd7) begin
              pull_d  = 1'b0;
              state_d = ST_RACK;
            end else begin
              bit_d  = bit_q + 1'b1;
              sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
              pull_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_f;
          end else if (scl_fall) begin
            if (mack_q) begin
              bit_d   = '0;
              sh_d    = tx_byte;
              pull_d  = ~tx_byte[BYTE_W-1];
              state_d = ST_RDAT;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      pull_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      pull_q  <= pull_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      scl_p_q <= scl_f;
      sda_p_q <= sda_f;
    end
  end

  assign sda_pull = pull_q;
  assign wr_mask  = sh_q[CH-1:0];

endmodule

// File: rtl/chsel_sel_reg.sv
// Staged channel mask: written bytes land in a pending copy that is
// transferred to the live mask when a stop condition is seen.
module chsel_sel_reg #(
  parameter int unsigned CH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic [CH-1:0] wr_mask,
  input  logic          stop_evt,
  output logic [CH-1:0] live_mask
);

  logic [CH-1:0] pend_q, pend_d;
  logic          pend_v_q, pend_v_d;
  logic [CH-1:0] live_q, live_d;

  always_comb begin
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    live_d   = live_q;
    if (wr_fire) begin
      pend_d   = wr_mask;
      pend_v_d = 1'b1;
    end else if (stop_evt) begin
      if (pend_v_q) begin
        live_d = pend_q;
      end
      pend_v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      live_q   <= '0;
    end else begin
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
      live_q   <= live_d;
    end
  end

  assign live_mask = live_q;

endmodule

// File: rtl/chsel_top.sv
module chsel_top
  import chsel_pkg::*;
#(
  parameter int unsigned       CH        = 4,
  parameter int unsigned       STRAP_W   = 3,
  parameter int unsigned       FILT_CYC  = 5,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 7'h70
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_in_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap,
  output logic               sda_pull,
  output logic [CH-1:0]      chan_en
);

  localparam int unsigned N_LINES = 2;

  logic               arst_n;
  logic               rst_n_s;
  logic [N_LINES-1:0] raw_lines;
  logic [N_LINES-1:0] clean_lines;
  logic               scl_f, sda_f;
  logic               wr_fire;
  logic [CH-1:0]      wr_mask;
  logic               stop_evt;
  logic               start_evt;
  logic [CH-1:0]      live_mask;

  assign arst_n = por_n & rst_in_n;

  chsel_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n_s)
  );

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    chsel_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .line_i (raw_lines[g]),
      .line_o (clean_lines[g])
    );
  end

  assign scl_f = clean_lines[0];
  assign sda_f = clean_lines[1];

  chsel_bus_fsm #(
    .CH        (CH),
    .STRAP_W   (STRAP_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .scl_f     (scl_f),
    .sda_f     (sda_f),
    .strap     (strap),
    .cur_sel   (live_mask),
    .sda_pull  (sda_pull),
    .wr_fire   (wr_fire),
    .wr_mask   (wr_mask),
    .stop_evt  (stop_evt),
    .start_evt (start_evt)
  );

  chsel_sel_reg #(.CH(CH)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_fire   (wr_fire),
    .wr_mask   (wr_mask),
    .stop_evt  (stop_evt),
    .live_mask (live_mask)
  );

  assign chan_en = live_mask;

endmodule

// File: rtl/chsel_sva.sv
module chsel_sva #(
  parameter int unsigned CH = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_f,
  input logic          stop_evt,
  input logic          start_evt,
  input logic          sda_pull,
  input logic [CH-1:0] chan_en
);

  // R4: outputs move only in the cycle after a stop condition
  a_r4_hold_until_stop: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_evt |=> $stable(chan_en));

  // R10: the pull-down is only switched on while the clock line is low
  a_r10_pull_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_f);

  // R10: the line is free after a stop
  a_r10_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);

  // R9: a (repeated) start always frees the line
  a_r9_start_frees_line: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pull);

  // R7: while reset is held nothing is enabled or pulled
  a_r7_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (chan_en == '0 && !sda_pull));

endmodule

bind chsel_top chsel_sva #(.CH(CH)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .scl_f     (scl_f),
  .stop_evt  (stop_evt),
  .start_evt (start_evt),
  .sda_pull  (sda_pull),
  .chan_en   (chan_en)
);

// File: tb/test_chsel_top.sv
`timescale 1ns/1ps
module test_chsel_top;

  localparam int Q = 20;

  logic       clk;
  logic       por_n, rst_in_n;
  logic       scl_m, sda_m;
  logic [2:0] strap;
  logic       sda_pull;
  logic [3:0] chan_en;
  logic       sda_line;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // reference model
  logic [3:0] exp_sel;
  logic [3:0] exp_pend;
  bit         exp_pv;
  bit         cmp_on;
  bit         hold;

  assign sda_line = sda_m & ~sda_pull;

  chsel_top i_chsel_top (
    .clk      (clk),
    .por_n    (por_n),
    .rst_in_n (rst_in_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .strap    (strap),
    .sda_pull (sda_pull),
    .chan_en  (chan_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // per-clock comparison of the live mask against the model (R4)
  always @(negedge clk) begin
    if (cmp_on && !hold) chk(chan_en == exp_sel, "R4 per-cycle mask", chan_en, exp_sel);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_up();
    end
  end

  task automatic wc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; wc(Q);
    sda_m = 1'b0; wc(Q);
    scl_m = 1'b0; wc(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wc(Q);
    scl_m = 1'b1; wc(Q);
    sda_m = 1'b0; wc(Q);
    scl_m = 1'b0; wc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wc(Q);
    scl_m = 1'b1; wc(Q);
    sda_m = 1'b1; hold = 1; wc(Q);
    if (exp_pv) exp_sel = exp_pend;
    exp_pv = 0;
    hold = 0;
    wc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wc(Q);
      scl_m = 1'b1; wc(Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wc(Q);
    scl_m = 1'b1; wc(Q / 2);
    ack = sda_line;
    wc(Q / 2);
    scl_m = 1'b0; wc(Q);
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wc(Q);
      scl_m = 1'b1; wc(Q / 2);
      b[i] = sda_line;
      wc(Q / 2);
      scl_m = 1'b0;
    end
    wc(Q / 2);
    sda_m = give_ack ? 1'b0 : 1'b1; wc(Q / 2);
    scl_m = 1'b1; wc(Q);
    scl_m = 1'b0; wc(Q);
    sda_m = 1'b1;
  endtask

  // one write transaction to our address; model staged per acked byte
  task automatic write_mask(input logic [7:0] d, input string req);
    logic a;
    bus_start();
    send_byte(8'hEA, a);
    chk(a == 1'b0, "R1 address ack", a, 0);
    send_byte(d, a);
    chk(a == 1'b0, req, a, 0);
    exp_pend = d[3:0]; exp_pv = 1;
    bus_stop();
  endtask

  initial begin
    logic       a;
    logic [7:0] rd;
    por_n = 1'b1; rst_in_n = 1'b1; scl_m = 1'b1; sda_m = 1'b1;
    strap = 3'b101;
    exp_sel = '0; exp_pend = '0; exp_pv = 0; cmp_on = 0; hold = 0;
    #1 por_n = 1'b0;
    wc(5);
    chk(chan_en == 4'h0, "R7 power-on mask", chan_en, 0);
    chk(sda_pull == 1'b0, "R7 power-on line free", sda_pull, 0);
    por_n = 1'b1;
    wc(5);
    cmp_on = 1;

    // R1/R3/R4: basic write, held until stop
    bus_start();
    send_byte(8'hEA, a);
    chk(a == 1'b0, "R1 match ack", a, 0);
    send_byte(8'h05, a);
    chk(a == 1'b0, "R3 data ack", a, 0);
    exp_pend = 4'h5; exp_pv = 1;
    wc(3 * Q);
    chk(chan_en == 4'h0, "R4 not applied before stop", chan_en, 0);
    bus_stop();
    chk(chan_en == 4'h5, "R3 mask applied", chan_en, 5);

    // R4 prior selection kept until stop
    bus_start();
    send_byte(8'hEA, a);
    send_byte(8'h0A, a);
    exp_pend = 4'hA; exp_pv = 1;
    wc(2 * Q);
    chk(chan_en == 4'h5, "R4 previous mask holds", chan_en, 5);
    bus_stop();
    chk(chan_en == 4'hA, "R4 applied at stop", chan_en, 'hA);

    // R5 last of several bytes wins
    bus_start();
    send_byte(8'hEA, a);
    send_byte(8'h03, a); exp_pend = 4'h3; exp_pv = 1;
    send_byte(8'h06, a); exp_pend = 4'h6;
    send_byte(8'h0C, a); exp_pend = 4'hC;
    chk(a == 1'b0, "R5 every byte acked", a, 0);
    bus_stop();
    chk(chan_en == 4'hC, "R5 last byte kept", chan_en, 'hC);

    // R3 upper nibble ignored, then R6 read back
    write_mask(8'hF3, "R3 upper nibble write ack");
    chk(chan_en == 4'h3, "R3 upper nibble ignored", chan_en, 3);
    bus_start();
    send_byte(8'hEB, a);
    chk(a == 1'b0, "R1 read address ack", a, 0);
    read_byte(1'b0, rd);
    chk(rd == 8'h03, "R6 read value", rd, 3);
    bus_stop();
    chk(sda_pull == 1'b0, "R6 line released after NACK", sda_pull, 0);

    // R3 all and none
    write_mask(8'h0F, "R3 all ack");
    chk(chan_en == 4'hF, "R3 all channels", chan_en, 'hF);
    write_mask(8'h00, "R3 none ack");
    chk(chan_en == 4'h0, "R3 no channel", chan_en, 0);

    // R2 wrong strap value: no ack, data ignored
    bus_start();
    send_byte(8'hE8, a);
    chk(a == 1'b1, "R2 no ack on mismatch", a, 1);
    send_byte(8'h0F, a);
    chk(a == 1'b1, "R2 data ignored", a, 1);
    bus_stop();
    chk(chan_en == 4'h0, "R2 mask untouched", chan_en, 0);

    // R9 repeated start: read returns old mask, commit at final stop
    write_mask(8'h06, "R9 setup ack");
    bus_start();
    send_byte(8'hEA, a);
    send_byte(8'h09, a); exp_pend = 4'h9; exp_pv = 1;
    bus_rstart();
    send_byte(8'hEB, a);
    chk(a == 1'b0, "R9 address after repeated start", a, 0);
    read_byte(1'b0, rd);
    chk(rd == 8'h06, "R9 read sees old mask", rd, 6);
    chk(chan_en == 4'h6, "R9 not yet applied", chan_en, 6);
    bus_stop();
    chk(chan_en == 4'h9, "R9 applied at final stop", chan_en, 9);

    // R8 short spike on SDA while SCL high is not a stop
    bus_start();
    send_byte(8'hEA, a);
    send_byte(8'h01, a); exp_pend = 4'h1; exp_pv = 1;
    sda_m = 1'b0; wc(Q);
    scl_m = 1'b1; wc(Q);
    sda_m = 1'b1; wc(2);
    sda_m = 1'b0; wc(Q);
    chk(chan_en == 4'h9, "R8 spike rejected", chan_en, 9);
    scl_m = 1'b0; wc(Q);
    bus_stop();
    chk(chan_en == 4'h1, "R8 real stop still applies", chan_en, 1);

    // R7 reset pin mid-transaction
    bus_start();
    send_byte(8'hEA, a);
    send_byte(8'h0E, a);
    hold = 1;
    rst_in_n = 1'b0;
    exp_sel = '0; exp_pv = 0;
    wc(3);
    chk(chan_en == 4'h0, "R7 reset pin clears mask", chan_en, 0);
    chk(sda_pull == 1'b0, "R7 reset pin frees line", sda_pull, 0);
    rst_in_n = 1'b1;
    wc(5);
    hold = 0;
    bus_stop();
    chk(chan_en == 4'h0, "R7 staged mask discarded", chan_en, 0);
    write_mask(8'h02, "R7 works after reset");
    chk(chan_en == 4'h2, "R7 write after reset", chan_en, 2);

    cmp_on = 0;
    finish_up();
  end

endmodule